// File: doc/BRIEF.md
# Down-Counting Compare Interrupt Timer

This block is a memory-mapped 32-bit timer for use as a system event source. A down counter advances once per prescaled, qualified count tick. On reaching zero it either reloads from a programmable start value or wraps freely through the full 32-bit range. Software schedules an event by reading the running count, subtracting the wanted delay, and writing the result into the compare register. When the counter steps onto that value, a sticky status flag is raised. The flag drives a level interrupt and can also toggle, set or clear a single output pin.

Software reaches five 32-bit registers through a single-cycle write strobe and a combinational read port. The count tick arrives on its own input. A two-bit source select in the control word only gates that tick; it does not multiplex between clocks. A software reset bit returns the timer to an idle state without touching the load or compare values.

Top module: `cmpTimer`

## Requirements
- R1: After hardware reset the control word reads 0, status 0, load 0xFFFFFFFF, compare 0 and counter 0xFFFFFFFF, with the interrupt and the pin low.
- R2: Byte offsets are control 0x00, status 0x04, load 0x08, compare 0x0C and counter 0x10. Load and compare read back what was written, and a write to the counter offset leaves the count unchanged.
- R3: With control bit 0 set, tickIn high and source select (bits 25:24) nonzero, the counter steps once every P+1 cycles, where P is control bits 15:4. If any one of these three conditions is absent, the counter holds.
- R4: With control bit 3 set (reload), a step taken from count 0 loads the load register value.
- R5: With control bit 3 clear (free run), a step taken from count 0 gives 0xFFFFFFFF.
- R6: When a control write raises bit 0 while bit 1 is set, the counter takes the load value and the prescaler restarts. When bit 1 is clear, the counter resumes from its held value.
- R7: When control bit 17 is set, a write to the load register also copies the written value into the counter on the same edge. When bit 17 is clear, the counter is unaffected by the load write.
- R8: Status bit 0 is set on the edge where a count step makes the counter equal to the compare register. It stays set until a write of 1 to status bit 0; writing 0 has no effect.
- R9: If a status clear and a compare match fall on the same edge, the flag stays set.
- R10: irqOut is high exactly when status bit 0 and control bit 2 are both set.
- R11: Control bits 23:22 set the pin action on a match: 0 holds, 1 toggles, 2 drives low, 3 drives high.
- R12: Writing control bit 16 makes control read 0x00010000 for one cycle. After that, control reads 0, the flag is clear, the counter is 0xFFFFFFFF and the pin is low. Load and compare are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| tickIn | input | 1 | Count tick from the selected source |
| irqOut | output | 1 | Level interrupt |
| pinOut | output | 1 | Compare-driven output pin |

## Verification
The bench sweeps the prescaler from 0 to 3 and checks the count on every cycle against floor(cycles/(P+1)). A prescaler that is off by one, or that skips its restart on enable, shows up as a drifting count.

Reload and free-run sequences are followed cycle by cycle across the zero crossing. A design that mixed up the two modes would show 0xFFFFFFFF where the load value belongs, or the reverse.

A status clear is driven onto the exact edge of a match. A design that gave the clear priority would drop the event.

The three pin actions are run in sequence against a bench model of the pin. After a software reset, the bench checks that the control word reads back for one cycle and then clears, while load and compare keep their values.

// File: rtl/cmpTimerPkg.sv
package cmpTimerPkg;
  localparam int unsigned BIT_EN      = 0;
  localparam int unsigned BIT_RESTART = 1;
  localparam int unsigned BIT_IRQEN   = 2;
  localparam int unsigned BIT_RELOAD  = 3;
  localparam int unsigned BIT_PRESC   = 4;
  localparam int unsigned BIT_SWR     = 16;
  localparam int unsigned BIT_OVW     = 17;
  localparam int unsigned BIT_PIN     = 22;
  localparam int unsigned BIT_SRC     = 24;

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_LOW    = 2'd2,
    PIN_HIGH   = 2'd3
  } pinAct_e;

  typedef struct packed {
    logic swr;
    logic overwrite;
    logic restart;
    logic step;
    logic stsClr;
  } tmrStrobe_t;
endpackage

// File: rtl/cmpTimerCtrl.sv
module cmpTimerCtrl
  import cmpTimerPkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned PRESC_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickIn,
  input  logic [DATA_W-1:0] countVal,
  input  logic              flagVal,
  output tmrStrobe_t        strobe,
  output logic              reloadMode,
  output pinAct_e           pinMode,
  output logic              irqEn,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] cmpVal
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] OFS_LOAD = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] OFS_CMP  = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(5'h10);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(32'h03C3_FFFF);
  localparam logic [DATA_W-1:0] SWR_ONLY  = DATA_W'(1) << BIT_SWR;

  logic [DATA_W-1:0]  ctrlReg;
  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W-1:0] prescLim;
  logic               swrActive;
  logic               wrCtrl, wrStat, wrLoad, wrCmp;
  logic               tickQual;
  logic               enRise;

  assign swrActive  = ctrlReg[BIT_SWR];
  assign prescLim   = ctrlReg[BIT_PRESC +: PRESC_W];
  assign reloadMode = ctrlReg[BIT_RELOAD];
  assign pinMode    = pinAct_e'(ctrlReg[BIT_PIN +: 2]);
  assign irqEn      = ctrlReg[BIT_IRQEN];

  assign wrCtrl = busWr && (busAddr == OFS_CTRL);
  assign wrStat = busWr && (busAddr == OFS_STAT);
  assign wrLoad = busWr && (busAddr == OFS_LOAD);
  assign wrCmp  = busWr && (busAddr == OFS_CMP);

  assign tickQual = tickIn && ctrlReg[BIT_EN] && (ctrlReg[BIT_SRC +: 2] != 2'd0) && !swrActive;
  assign enRise   = wrCtrl && !swrActive && !busWdata[BIT_SWR]
                    && busWdata[BIT_EN] && !ctrlReg[BIT_EN];

  always_comb begin
    strobe.swr       = swrActive;
    strobe.overwrite = wrLoad && ctrlReg[BIT_OVW] && !swrActive;
    strobe.restart   = enRise && busWdata[BIT_RESTART];
    strobe.step      = tickQual && (prescCnt >= prescLim);
    strobe.stsClr    = wrStat && busWdata[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (swrActive) begin
      ctrlReg <= '0;
    end else if (wrCtrl) begin
      if (busWdata[BIT_SWR]) ctrlReg <= SWR_ONLY;
      else                   ctrlReg <= busWdata & CTRL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadVal <= '1;
      cmpVal  <= '0;
    end else begin
      if (wrLoad) loadVal <= busWdata;
      if (wrCmp)  cmpVal  <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else if (swrActive || enRise) begin
      prescCnt <= '0;
    end else if (tickQual) begin
      if (strobe.step) prescCnt <= '0;
      else             prescCnt <= prescCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (busAddr)
      OFS_CTRL: busRdata = ctrlReg;
      OFS_STAT: busRdata = {{(DATA_W-1){1'b0}}, flagVal};
      OFS_LOAD: busRdata = loadVal;
      OFS_CMP:  busRdata = cmpVal;
      OFS_CNT:  busRdata = countVal;
      default:  busRdata = '0;
    endcase
  end

  // R12: the reset bit lasts one cycle and leaves the control word empty
  a_r12_swr_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    swrActive |=> (ctrlReg == '0));

  // R3: with a nonzero prescaler two steps are never adjacent
  a_r3_step_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && prescLim != '0 && !enRise && !wrCtrl) |=> !strobe.step);

  // R3: no step without a qualified tick
  a_r3_gated: assert property (@(posedge clk) disable iff (!rstN)
    (!tickIn || !ctrlReg[BIT_EN]) |-> !strobe.step);
endmodule

// File: rtl/cmpTimerDatapath.sv
module cmpTimerDatapath
  import cmpTimerPkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic              reloadMode,
  input  pinAct_e           pinMode,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] cmpVal,
  input  logic [DATA_W-1:0] ovwData,
  output logic [DATA_W-1:0] countVal,
  output logic              flagVal,
  output logic              pinVal
);
  logic [DATA_W-1:0] stepNext;
  logic              matchEvt;

  assign stepNext = (reloadMode && countVal == '0) ? loadVal : countVal - 1'b1;
  assign matchEvt = strobe.step && !strobe.overwrite && !strobe.swr && (stepNext == cmpVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '1;
    end else if (strobe.swr) begin
      countVal <= '1;
    end else if (strobe.overwrite) begin
      countVal <= ovwData;
    end else if (strobe.restart) begin
      countVal <= loadVal;
    end else if (strobe.step) begin
      countVal <= stepNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagVal <= 1'b0;
    end else if (strobe.swr) begin
      flagVal <= 1'b0;
    end else if (matchEvt) begin
      flagVal <= 1'b1;
    end else if (strobe.stsClr) begin
      flagVal <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinVal <= 1'b0;
    end else if (strobe.swr) begin
      pinVal <= 1'b0;
    end else if (matchEvt) begin
      unique case (pinMode)
        PIN_TOGGLE: pinVal <= !pinVal;
        PIN_LOW:    pinVal <= 1'b0;
        PIN_HIGH:   pinVal <= 1'b1;
        default:    pinVal <= pinVal;
      endcase
    end
  end

  // R3: without any strobe the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.overwrite && !strobe.restart && !strobe.swr) |=> $stable(countVal));

  // R4: reload from zero
  a_r4_reload: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && reloadMode && countVal == '0 && !strobe.swr && !strobe.overwrite)
    |=> (countVal == $past(loadVal)));

  // R5: free-run wrap from zero
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !reloadMode && countVal == '0 && !strobe.swr && !strobe.overwrite)
    |=> (countVal == '1));

  // R8: the flag only rises on a step
  a_r8_flag_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagVal) |-> $past(strobe.step));

  // R8: the flag is sticky until cleared
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagVal && !strobe.stsClr && !strobe.swr) |=> flagVal);

  // R11: toggle mode flips the pin on a match
  a_r11_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvt && pinMode == PIN_TOGGLE) |=> (pinVal != $past(pinVal)));
endmodule

// File: rtl/cmpTimer.sv
module cmpTimer
  import cmpTimerPkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned PRESC_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickIn,
  output logic              irqOut,
  output logic              pinOut
);
  tmrStrobe_t        strobe;
  logic              reloadMode;
  pinAct_e           pinMode;
  logic              irqEn;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] cmpVal;
  logic [DATA_W-1:0] countVal;
  logic              flagVal;

  cmpTimerCtrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESC_W(PRESC_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .tickIn(tickIn), .countVal(countVal), .flagVal(flagVal),
    .strobe(strobe), .reloadMode(reloadMode), .pinMode(pinMode), .irqEn(irqEn),
    .loadVal(loadVal), .cmpVal(cmpVal)
  );

  cmpTimerDatapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadMode(reloadMode), .pinMode(pinMode),
    .loadVal(loadVal), .cmpVal(cmpVal), .ovwData(busWdata), .countVal(countVal),
    .flagVal(flagVal), .pinVal(pinOut)
  );

  assign irqOut = flagVal && irqEn;

  // R10: a raised interrupt implies a raised flag
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> flagVal);
endmodule

// File: tb/test_cmpTimer.sv
module test_cmpTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickIn = 1'b1;
  logic        irqOut;
  logic        pinOut;
  int          errors = 0;
  int          checks = 0;

  localparam logic [31:0] EN = 32'h1, RST = 32'h2, IEN = 32'h4, RLD = 32'h8;
  localparam logic [31:0] SWR = 32'h1_0000, OVW = 32'h2_0000, SRC = 32'h100_0000;

  always #2 clk = !clk;

  cmpTimer i_cmpTimer (.clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tickIn(tickIn), .irqOut(irqOut), .pinOut(pinOut));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic softReset();
    wr(5'h00, SWR); cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, held, expCnt;
    logic        expPin;
    cyc(2);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(5'h00, v); chk("R1 ctrl", v, 0);
    rd(5'h04, v); chk("R1 status", v, 0);
    rd(5'h08, v); chk("R1 load", v, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R1 compare", v, 0);
    rd(5'h10, v); chk("R1 counter", v, 32'hFFFF_FFFF);
    chk("R1 irq", irqOut, 0);
    chk("R1 pin", pinOut, 0);

    // R2 register access, counter write ignored
    wr(5'h08, 32'h1234_5678); rd(5'h08, v); chk("R2 load rw", v, 32'h1234_5678);
    wr(5'h0C, 32'hCAFE_0001); rd(5'h0C, v); chk("R2 cmp rw", v, 32'hCAFE_0001);
    wr(5'h10, 32'h5); rd(5'h10, v); chk("R2 counter write ignored", v, 32'hFFFF_FFFF);
    wr(5'h0C, 32'h0);

    // R3 prescaler sweep with R6 restart
    for (int p = 0; p < 4; p++) begin
      wr(5'h00, 0);
      wr(5'h08, 100);
      wr(5'h00, EN | RST | RLD | SRC | (32'(p) << 4));
      busAddr = 5'h10;
      for (int n = 0; n < 10; n++) begin
        #1; chk("R3 prescaled count", busRdata, 32'(100 - n / (p + 1)));
        cyc(1);
      end
    end

    // R3 gating: source select zero, tick low
    wr(5'h00, 0);
    wr(5'h08, 50);
    wr(5'h00, EN | RST | RLD);
    cyc(4); rd(5'h10, v); chk("R3 source off holds", v, 50);
    wr(5'h00, 0);
    tickIn = 1'b0;
    wr(5'h00, EN | RST | RLD | SRC);
    cyc(4); rd(5'h10, v); chk("R3 tick low holds", v, 50);
    tickIn = 1'b1;
    cyc(3); rd(5'h10, v); chk("R3 tick resumes", v, 47);

    // R6 resume without restart
    wr(5'h00, RLD | SRC);
    rd(5'h10, held);
    cyc(3); rd(5'h10, v); chk("R3 disabled holds", v, held);
    wr(5'h00, EN | RLD | SRC);
    rd(5'h10, v); chk("R6 resume keeps count", v, held);
    cyc(2); rd(5'h10, v); chk("R6 resume continues", v, held - 2);

    // R7 overwrite on load write
    wr(5'h00, 0);
    rd(5'h10, held);
    wr(5'h08, 32'h77); rd(5'h10, v); chk("R7 no overwrite", v, held);
    wr(5'h00, OVW);
    wr(5'h08, 32'h99); rd(5'h10, v); chk("R7 overwrite", v, 32'h99);

    // R4 reload sequence
    wr(5'h00, 0); wr(5'h08, 3);
    wr(5'h00, EN | RST | RLD | SRC);
    busAddr = 5'h10;
    for (int n = 0; n < 10; n++) begin
      #1; chk("R4 reload sequence", busRdata, 32'(3 - n % 4));
      cyc(1);
    end

    // R5 free run wrap
    wr(5'h00, 0); wr(5'h08, 2);
    wr(5'h00, EN | RST | SRC);
    busAddr = 5'h10;
    for (int n = 0; n < 6; n++) begin
      #1; chk("R5 free run", busRdata, 32'(2 - n));
      cyc(1);
    end

    // R12 software reset
    wr(5'h0C, 32'h42);
    wr(5'h00, SWR | EN | RLD);
    rd(5'h00, v); chk("R12 reset bit visible", v, SWR);
    cyc(1);
    rd(5'h00, v); chk("R12 ctrl cleared", v, 0);
    rd(5'h10, v); chk("R12 counter", v, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R12 compare kept", v, 32'h42);
    rd(5'h08, v); chk("R12 load kept", v, 2);

    // R8 / R10 compare flag and interrupt
    wr(5'h08, 10); wr(5'h0C, 7);
    wr(5'h00, EN | RST | IEN | RLD | SRC);
    cyc(2);
    rd(5'h04, v); chk("R8 no early flag", v, 0);
    chk("R10 irq low", irqOut, 0);
    cyc(1);
    rd(5'h04, v); chk("R8 flag on match", v, 1);
    chk("R10 irq high", irqOut, 1);
    wr(5'h00, IEN | RLD | SRC);
    wr(5'h04, 0); rd(5'h04, v); chk("R8 write 0 ignored", v, 1);
    wr(5'h00, RLD | SRC);
    chk("R10 irq masked", irqOut, 0);
    wr(5'h04, 1); rd(5'h04, v); chk("R8 write 1 clears", v, 0);

    // R9 clear and match on the same edge
    wr(5'h00, EN | RST | RLD | SRC);
    cyc(2);
    wr(5'h04, 1);
    rd(5'h04, v); chk("R9 match wins over clear", v, 1);
    rd(5'h10, v); chk("R9 count at match", v, 7);

    // R11 pin actions: toggle, then set, then clear
    softReset();
    chk("R12 pin low", pinOut, 0);
    wr(5'h08, 3); wr(5'h0C, 1);
    expPin = 1'b0;
    for (int m = 0; m < 3; m++) begin
      logic [1:0] mode;
      mode = (m == 0) ? 2'd1 : (m == 1) ? 2'd3 : 2'd2;
      wr(5'h00, EN | RST | RLD | SRC | (32'(mode) << 22));
      expCnt = 3;
      for (int n = 0; n < 9; n++) begin
        cyc(1);
        expCnt = (expCnt == 0) ? 32'd3 : expCnt - 1;
        if (expCnt == 1) begin
          if (mode == 2'd1) expPin = !expPin;
          else if (mode == 2'd3) expPin = 1'b1;
          else expPin = 1'b0;
        end
        chk("R11 pin action", pinOut, expPin);
      end
      wr(5'h00, 0);
      expCnt = (expCnt == 0) ? 32'd3 : expCnt - 1;
      if (expCnt == 1) begin
        if (mode == 2'd1) expPin = !expPin;
        else if (mode == 2'd3) expPin = 1'b1;
        else expPin = 1'b0;
      end
      chk("R11 pin after stop", pinOut, expPin);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule